// File: doc/BRIEF.md
# Codec Programmed-I/O Transfer Status Register

This block is the eight-bit status register that a host polls when it moves audio samples to and from a codec one byte at a time, with no DMA. For the playback direction it reports whether the outgoing data register may be written, and for the capture direction whether a fresh sample is waiting to be read. For each direction it also reports which channel the next byte belongs to and which half of a 16-bit sample it is. Two frame pointers step through each sample frame according to the selected format: 8 or 16 bits, mono or stereo.

A shared flag reports that the most recent sample tick found its direction unserviced. That means a capture overrun or a playback underrun. Separate overrun and underrun flags are also brought out so the two causes can be told apart. A sticky interrupt flag is set by a DMA count-underflow pulse and is cleared by any host write to the register. The interrupt pin shows that flag only while the interrupt enable is high. A host read captures the register value of that same cycle onto `rdData`.

Top module: `pio_xfer_status`

## Requirements
- R1: After reset, with `fmtWide`=0 and `fmtStereo`=0, `statusByte` reads 8'hCC, and `rdData`, `intPin`, `overrunFlag` and `underrunFlag` are 0.
- R2: Bit 0 of `statusByte` is the interrupt flag. A `dmaUnderflow` pulse sets it, and it then stays set. A `hostWr` clears it whatever the data, and leaves bits 7:1 unchanged. If `hostWr` and `dmaUnderflow` arrive in the same cycle, the flag is set.
- R3: `intPin` is 1 exactly when bit 0 is 1 and `intEnable` is 1.
- R4: Bit 1 is playback-ready and is 0 after reset. A `playTick` while it is 0 sets it to 1. A `playDataWr` is accepted only while it is 1. The write that fills the last byte of the frame clears it to 0. Writes while it is 0 are ignored.
- R5: Bit 3 is the playback upper/lower bit and bit 2 is the playback left/right bit. Bit 3 is 1 in 8-bit mode and otherwise 1 for the upper byte and 0 for the lower byte. Bit 2 is 1 for mono or the left channel and 0 for the right channel. Each accepted write moves the pointer from lower to upper byte, and after the upper byte from the left to the right channel. After the final byte the pointer wraps to the left channel, lower byte.
- R6: A `playTick` while playback-ready is 1 sets `underrunFlag` and rewinds the playback pointer to the left channel, lower byte. A `playTick` while it is 0 clears `underrunFlag`.
- R7: Bit 5 is capture-ready and is 0 after reset. Every `capTick` sets it to 1. A `capDataRd` while it is 1 advances the capture pointer, and the read of the last byte clears it. Reads while it is 0 are ignored.
- R8: Bit 7 is the capture upper/lower bit and bit 6 is the capture left/right bit. They use the same encoding and stepping as R5, driven by accepted capture reads. Every `capTick` rewinds the capture pointer to the left channel, lower byte.
- R9: A `capTick` sets `overrunFlag` if capture-ready was 1 before the tick, and clears it otherwise.
- R10: Bit 4 is 1 exactly when `overrunFlag` or `underrunFlag` is 1.
- R11: One cycle after a `hostRd`, `rdData` holds the `statusByte` value of the cycle of the read, and it holds that value until the next read.
- R12: A sample tick in the same cycle as a data access of that direction takes precedence, and the access is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostRd | input | 1 | Host read strobe for this register |
| hostWr | input | 1 | Host write strobe for this register |
| playTick | input | 1 | Playback converter takes a sample frame |
| capTick | input | 1 | Capture converter delivers a sample frame |
| playDataWr | input | 1 | Host byte write to the playback data register |
| capDataRd | input | 1 | Host byte read of the capture data register |
| fmtWide | input | 1 | 1 = 16-bit samples, 0 = 8-bit |
| fmtStereo | input | 1 | 1 = stereo, 0 = mono |
| dmaUnderflow | input | 1 | DMA current-count underflow pulse |
| intEnable | input | 1 | Lets the interrupt flag reach the pin |
| statusByte | output | 8 | Live status register value |
| rdData | output | 8 | Value captured by the last host read |
| intPin | output | 1 | Interrupt output, active high |
| overrunFlag | output | 1 | Last capture tick found unread data |
| underrunFlag | output | 1 | Last playback tick found an incomplete frame |

## Verification
The bench builds the block with its default two-direction datapath. Because the frame format is a run-time input, one elaboration covers all four formats, and the format is switched both between frames and in mid-frame. Random strobes make ticks land on partly filled and partly drained frames, which brings both rewind paths and both error flags within reach. Directed steps walk a full 16-bit stereo frame byte by byte and place ticks in the same cycle as data accesses.

// File: rtl/pio_status_pkg.sv
package pio_status_pkg;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_PLAY = 0;
  localparam int unsigned DIR_CAP  = 1;

  typedef struct packed {
    logic [NUM_DIR-1:0] step;
    logic [NUM_DIR-1:0] rewind;
  } ptrCmd_t;
endpackage

// File: rtl/pio_frame_ptr.sv
module pio_frame_ptr (
  input  logic clk,
  input  logic rstN,
  input  logic wide,
  input  logic stereo,
  input  logic step,
  input  logic rewind,
  output logic upperBit,
  output logic leftBit,
  output logic atLast
);
  logic byteHi;
  logic chanRight;

  assign atLast   = (!wide | byteHi) & (!stereo | chanRight);
  assign upperBit = !wide | byteHi;
  assign leftBit  = !stereo | !chanRight;

  always_ff @(posedge clk) begin
    if (!rstN || rewind) begin
      byteHi    <= 1'b0;
      chanRight <= 1'b0;
    end else if (step) begin
      if (wide && !byteHi) begin
        byteHi <= 1'b1;
      end else begin
        byteHi <= 1'b0;
        if (stereo && !chanRight) chanRight <= 1'b1;
        else                      chanRight <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pio_status_ctrl.sv
module pio_status_ctrl
  import pio_status_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostWr,
  input  logic    playTick,
  input  logic    capTick,
  input  logic    playDataWr,
  input  logic    capDataRd,
  input  logic    dmaUnderflow,
  input  logic    playLast,
  input  logic    capLast,
  output ptrCmd_t cmd,
  output logic    playRdy,
  output logic    capRdy,
  output logic    overrun,
  output logic    underrun,
  output logic    intFlag
);
  always_comb begin
    cmd = '0;
    cmd.rewind[DIR_PLAY] = playTick & playRdy;
    cmd.step[DIR_PLAY]   = !playTick & playDataWr & playRdy;
    cmd.rewind[DIR_CAP]  = capTick;
    cmd.step[DIR_CAP]    = !capTick & capDataRd & capRdy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      playRdy  <= 1'b0;
      underrun <= 1'b0;
    end else if (playTick) begin
      if (playRdy) begin
        underrun <= 1'b1;
      end else begin
        playRdy  <= 1'b1;
        underrun <= 1'b0;
      end
    end else if (cmd.step[DIR_PLAY] && playLast) begin
      playRdy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capRdy  <= 1'b0;
      overrun <= 1'b0;
    end else if (capTick) begin
      overrun <= capRdy;
      capRdy  <= 1'b1;
    end else if (cmd.step[DIR_CAP] && capLast) begin
      capRdy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             intFlag <= 1'b0;
    else if (dmaUnderflow) intFlag <= 1'b1;
    else if (hostWr)       intFlag <= 1'b0;
  end
endmodule

// File: rtl/pio_status_datapath.sv
module pio_status_datapath
  import pio_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRd,
  input  logic              fmtWide,
  input  logic              fmtStereo,
  input  logic              intEnable,
  input  ptrCmd_t           cmd,
  input  logic              playRdy,
  input  logic              capRdy,
  input  logic              overrun,
  input  logic              underrun,
  input  logic              intFlag,
  output logic              playLast,
  output logic              capLast,
  output logic [STAT_W-1:0] statusByte,
  output logic [STAT_W-1:0] rdData,
  output logic              intPin
);
  logic [NUM_DIR-1:0] upperBits;
  logic [NUM_DIR-1:0] leftBits;
  logic [NUM_DIR-1:0] lastBits;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_ptr
    pio_frame_ptr u_ptr (
      .clk      (clk),
      .rstN     (rstN),
      .wide     (fmtWide),
      .stereo   (fmtStereo),
      .step     (cmd.step[d]),
      .rewind   (cmd.rewind[d]),
      .upperBit (upperBits[d]),
      .leftBit  (leftBits[d]),
      .atLast   (lastBits[d])
    );
  end

  assign playLast = lastBits[DIR_PLAY];
  assign capLast  = lastBits[DIR_CAP];

  assign statusByte = {upperBits[DIR_CAP], leftBits[DIR_CAP], capRdy,
                       overrun | underrun,
                       upperBits[DIR_PLAY], leftBits[DIR_PLAY], playRdy,
                       intFlag};

  assign intPin = intFlag & intEnable;

  always_ff @(posedge clk) begin
    if (!rstN)       rdData <= '0;
    else if (hostRd) rdData <= statusByte;
  end
endmodule

// File: rtl/pio_xfer_status.sv
module pio_xfer_status
  import pio_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic              playTick,
  input  logic              capTick,
  input  logic              playDataWr,
  input  logic              capDataRd,
  input  logic              fmtWide,
  input  logic              fmtStereo,
  input  logic              dmaUnderflow,
  input  logic              intEnable,
  output logic [STAT_W-1:0] statusByte,
  output logic [STAT_W-1:0] rdData,
  output logic              intPin,
  output logic              overrunFlag,
  output logic              underrunFlag
);
  ptrCmd_t cmd;
  logic    playRdy, capRdy, intFlag, playLast, capLast;

  pio_status_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .hostWr       (hostWr),
    .playTick     (playTick),
    .capTick      (capTick),
    .playDataWr   (playDataWr),
    .capDataRd    (capDataRd),
    .dmaUnderflow (dmaUnderflow),
    .playLast     (playLast),
    .capLast      (capLast),
    .cmd          (cmd),
    .playRdy      (playRdy),
    .capRdy       (capRdy),
    .overrun      (overrunFlag),
    .underrun     (underrunFlag),
    .intFlag      (intFlag)
  );

  pio_status_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .hostRd     (hostRd),
    .fmtWide    (fmtWide),
    .fmtStereo  (fmtStereo),
    .intEnable  (intEnable),
    .cmd        (cmd),
    .playRdy    (playRdy),
    .capRdy     (capRdy),
    .overrun    (overrunFlag),
    .underrun   (underrunFlag),
    .intFlag    (intFlag),
    .playLast   (playLast),
    .capLast    (capLast),
    .statusByte (statusByte),
    .rdData     (rdData),
    .intPin     (intPin)
  );
endmodule

// File: rtl/pio_xfer_status_chk.sv
module pio_xfer_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostRd,
  input logic       hostWr,
  input logic       playTick,
  input logic       capTick,
  input logic       dmaUnderflow,
  input logic       intEnable,
  input logic [7:0] statusByte,
  input logic [7:0] rdData,
  input logic       intPin,
  input logic       overrunFlag,
  input logic       underrunFlag
);
  // R2
  int_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaUnderflow |=> statusByte[0]);

  // R2
  int_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[0] && !hostWr) |=> statusByte[0]);

  // R2
  int_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && !dmaUnderflow) |=> !statusByte[0]);

  // R3
  int_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[0] && intEnable) |-> intPin);

  // R6
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (playTick && statusByte[1]) |=> (underrunFlag && statusByte[1]));

  // R4
  play_ready_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (playTick && !statusByte[1]) |=> (statusByte[1] && !underrunFlag));

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capTick && statusByte[5]) |=> (overrunFlag && statusByte[5]));

  // R11
  read_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRd |=> (rdData == $past(statusByte)));
endmodule

bind pio_xfer_status pio_xfer_status_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .hostRd       (hostRd),
  .hostWr       (hostWr),
  .playTick     (playTick),
  .capTick      (capTick),
  .dmaUnderflow (dmaUnderflow),
  .intEnable    (intEnable),
  .statusByte   (statusByte),
  .rdData       (rdData),
  .intPin       (intPin),
  .overrunFlag  (overrunFlag),
  .underrunFlag (underrunFlag)
);

// File: tb/tb_pio_xfer_status.sv
module tb_pio_xfer_status;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostRd = 0, hostWr = 0, playTick = 0, capTick = 0;
  logic playDataWr = 0, capDataRd = 0, fmtWide = 0, fmtStereo = 0;
  logic dmaUnderflow = 0, intEnable = 0;
  logic [7:0] statusByte, rdData;
  logic intPin, overrunFlag, underrunFlag;

  int checks = 0;
  int fails  = 0;

  // model state
  logic mInt, mPRdy, mCRdy, mOver, mUnder;
  logic mPB, mPC, mCB, mCC;
  logic [7:0] mRd;

  always #10 clk = ~clk;

  pio_xfer_status dut (
    .clk(clk), .rstN(rstN), .hostRd(hostRd), .hostWr(hostWr),
    .playTick(playTick), .capTick(capTick), .playDataWr(playDataWr),
    .capDataRd(capDataRd), .fmtWide(fmtWide), .fmtStereo(fmtStereo),
    .dmaUnderflow(dmaUnderflow), .intEnable(intEnable),
    .statusByte(statusByte), .rdData(rdData), .intPin(intPin),
    .overrunFlag(overrunFlag), .underrunFlag(underrunFlag)
  );

  function automatic logic [7:0] expStatus();
    return {(!fmtWide | mCB), (!fmtStereo | !mCC), mCRdy, (mOver | mUnder),
            (!fmtWide | mPB), (!fmtStereo | !mPC), mPRdy, mInt};
  endfunction

  function automatic logic atLast(input logic b, input logic c);
    return (!fmtWide | b) & (!fmtStereo | c);
  endfunction

  task automatic stepPtr(inout logic b, inout logic c);
    if (fmtWide && !b) b = 1'b1;
    else begin
      b = 1'b0;
      c = (fmtStereo && !c);
    end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mInt = 0; mPRdy = 0; mCRdy = 0; mOver = 0; mUnder = 0;
    mPB = 0; mPC = 0; mCB = 0; mCC = 0; mRd = 8'h00;
  endtask

  // Model the coming clock edge from the inputs now driven.
  task automatic modelEdge();
    logic [7:0] cur;
    logic last;
    cur = expStatus();
    if (hostRd) mRd = cur;
    if (dmaUnderflow) mInt = 1'b1;
    else if (hostWr) mInt = 1'b0;
    if (playTick) begin
      if (mPRdy) begin mUnder = 1'b1; mPB = 0; mPC = 0; end
      else begin mPRdy = 1'b1; mUnder = 1'b0; end
    end else if (playDataWr && mPRdy) begin
      last = atLast(mPB, mPC);
      stepPtr(mPB, mPC);
      if (last) mPRdy = 1'b0;
    end
    if (capTick) begin
      mOver = mCRdy; mCRdy = 1'b1; mCB = 0; mCC = 0;
    end else if (capDataRd && mCRdy) begin
      last = atLast(mCB, mCC);
      stepPtr(mCB, mCC);
      if (last) mCRdy = 1'b0;
    end
  endtask

  task automatic compareAll(input string tag);
    logic [7:0] e;
    e = expStatus();
    check({"R2 int bit ", tag}, {7'd0, statusByte[0]}, {7'd0, e[0]});
    check({"R3 intPin ", tag}, {7'd0, intPin}, {7'd0, mInt & intEnable});
    check({"R4 play ready ", tag}, {7'd0, statusByte[1]}, {7'd0, e[1]});
    check({"R5 play pointer ", tag}, {6'd0, statusByte[3:2]}, {6'd0, e[3:2]});
    check({"R6 underrun ", tag}, {7'd0, underrunFlag}, {7'd0, mUnder});
    check({"R7 cap ready ", tag}, {7'd0, statusByte[5]}, {7'd0, e[5]});
    check({"R8 cap pointer ", tag}, {6'd0, statusByte[7:6]}, {6'd0, e[7:6]});
    check({"R9 overrun ", tag}, {7'd0, overrunFlag}, {7'd0, mOver});
    check({"R10 shared error ", tag}, {7'd0, statusByte[4]}, {7'd0, e[4]});
    check({"R11 read data ", tag}, rdData, mRd);
  endtask

  // Inputs are driven at the falling edge; results are compared at the next one.
  task automatic cycle(input logic [7:0] s, input string tag);
    {hostRd, hostWr, playTick, capTick, playDataWr, capDataRd, dmaUnderflow, intEnable} = s;
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  localparam logic [7:0] S_RD = 8'h80, S_WR = 8'h40, S_PT = 8'h20, S_CT = 8'h10;
  localparam logic [7:0] S_PW = 8'h08, S_CR = 8'h04, S_DMA = 8'h02, S_IE = 8'h01;

  initial begin
    repeat (400000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1846));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset image in 8-bit mono
    check("R1 reset status", statusByte, 8'hCC);
    check("R1 reset rdData", rdData, 8'h00);
    check("R1 reset flags", {5'd0, intPin, overrunFlag, underrunFlag}, 8'h00);

    // Directed: 16-bit stereo walk (R5, R8)
    fmtWide = 1; fmtStereo = 1;
    cycle(S_RD, "fmt change");
    cycle(S_PT, "first play tick");
    check("R5 16b stereo start left lower", {6'd0, statusByte[3:2]}, 8'h01);
    cycle(S_PW, "w1");
    check("R5 left upper", {6'd0, statusByte[3:2]}, 8'h03);
    cycle(S_PW, "w2");
    check("R5 right lower", {6'd0, statusByte[3:2]}, 8'h00);
    cycle(S_PW | S_PT, "tick with write");
    check("R12 tick wins over write, underrun", {7'd0, underrunFlag}, 8'h01);
    check("R12 pointer rewound", {6'd0, statusByte[3:2]}, 8'h01);
    for (int i = 0; i < 4; i++) cycle(S_PW, "fill frame");
    check("R4 ready clears after last byte", {7'd0, statusByte[1]}, 8'h00);
    cycle(S_PW, "write ignored");
    check("R4 ignored write keeps pointer", {6'd0, statusByte[3:2]}, 8'h01);
    cycle(S_CT, "cap tick");
    cycle(S_CR, "r1");
    cycle(S_CT | S_CR, "cap tick with read");
    check("R12 read ignored on tick", {6'd0, statusByte[7:6]}, 8'h01);
    check("R9 overrun on tick with data waiting", {7'd0, overrunFlag}, 8'h01);
    cycle(S_DMA | S_WR, "dma and write");
    check("R2 set wins over clear", {7'd0, statusByte[0]}, 8'h01);
    cycle(S_IE, "enable");
    check("R3 pin with enable", {7'd0, intPin}, 8'h01);
    cycle(S_WR | S_IE, "clear");
    check("R2 write clears", {7'd0, statusByte[0]}, 8'h00);

    // Constrained random
    for (int n = 0; n < 6000; n++) begin
      logic [7:0] s;
      s = '0;
      if ($urandom_range(5) == 0)   s |= S_RD;
      if ($urandom_range(19) == 0)  s |= S_WR;
      if ($urandom_range(11) == 0)  s |= S_PT;
      if ($urandom_range(11) == 0)  s |= S_CT;
      if ($urandom_range(2) == 0)   s |= S_PW;
      if ($urandom_range(2) == 0)   s |= S_CR;
      if ($urandom_range(39) == 0)  s |= S_DMA;
      if ($urandom_range(1) == 0)   s |= S_IE;
      if ($urandom_range(299) == 0) begin
        fmtWide = 1'($urandom_range(1));
        fmtStereo = 1'($urandom_range(1));
      end
      cycle(s, "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule